// File: doc/BRIEF.md
# Multipurpose Lookup Table Cell

This cell holds a single 16-bit storage word and offers three personalities over it. As a logic element, the four select inputs pick one stored bit, so the word acts as the truth table of any four-input Boolean function. As a small memory, the same word becomes a 16x1 RAM. A write into it happens on the clock edge, and its read is combinational. As a delay line, the word turns into a 16-stage shift register. The select inputs then choose which stage drives the output, which gives a programmable delay of 1 to 16 enabled clocks. The last stage is always brought out on a chaining pin, so several cells can be strung together for longer delays.

A parallel load port models configuration loading. It replaces the whole word in any mode and wins over any write or shift in the same cycle. The read bit either goes straight to the output or passes through an output flip-flop that has a synchronous clear. In delay-line mode that flip-flop adds one more stage. Changing the mode never touches the stored word.

Top module: `mlut_cell`

## Requirements
- R1: With mode_i = 0 (logic) and obypass_i = 1, dout_o equals bit addr_i of the word most recently loaded through the init port, for every one of the 16 addresses.
- R2: With mode_i = 0, we_i and din_i have no effect: the stored word, read back through dout_o, is unchanged after clocks with we_i = 1.
- R3: With mode_i = 1 (RAM) and we_i = 1, the clock edge stores din_i at bit addr_i and leaves the other 15 bits unchanged.
- R4: With obypass_i = 1, dout_o follows a change of addr_i within the same cycle, with no clock edge in between.
- R5: With obypass_i = 0, dout_o shows the bit that was selected in the cycle before the most recent clock edge, in every mode.
- R6: With mode_i = 2 (shift) and we_i = 1, each edge moves bit i into bit i+1 and din_i into bit 0, so the tap at addr_i = k shows the din_i value from k+1 enabled shifts earlier.
- R7: With mode_i = 2 and we_i = 0, the stored word holds its value.
- R8: cascade_o always equals bit 15 of the word; in shift mode it shows the din_i from 16 enabled shifts earlier.
- R9: rst = 1 at a clock edge clears the output flip-flop, so dout_o reads 0 in the following cycle when obypass_i = 0; rst does not clear the stored word.
- R10: A change of mode_i leaves the stored word unchanged.
- R11: init_load_i = 1 replaces the whole word with init_data_i at the clock edge, and it takes priority over a RAM write or shift in the same cycle.
- R12: mode_i = 3 is reserved and behaves like logic mode: writes and shifts are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous clear of the output flip-flop only |
| mode_i | input | 2 | 0 logic, 1 RAM, 2 shift, 3 reserved (acts as logic) |
| addr_i | input | 4 | Function inputs, RAM address or shift tap select |
| we_i | input | 1 | RAM write enable / shift enable |
| din_i | input | 1 | RAM write data / serial shift input |
| init_load_i | input | 1 | Parallel configuration load strobe |
| init_data_i | input | 16 | Parallel configuration word, bit i at address i |
| obypass_i | input | 1 | 1 selects the combinational read, 0 the registered read |
| dout_o | output | 1 | Cell output |
| cascade_o | output | 1 | Last shift stage (bit 15), used for chaining |

## Verification
The bench aims at the write path in the modes where it must stay silent. Logic and reserved modes get writes with inverted data, and a cell that decoded the mode loosely would corrupt its truth table there. Shift taps are read at every depth while new bits keep entering. A shift aimed the wrong way, or taken from an off-by-one stage, shows up as the wrong delay, and the cascade pin is checked against a 16-deep history. Loads that coincide with a RAM write or a shift catch a wrong priority order. Reset with the registered output checks that only the flip-flop is cleared, and a mode switch after RAM writes checks that the contents survive.

// File: rtl/mlut_pkg.sv
package mlut_pkg;

  typedef enum logic [1:0] {
    MODE_LOGIC = 2'd0,
    MODE_RAM   = 2'd1,
    MODE_SHIFT = 2'd2,
    MODE_RSVD  = 2'd3
  } mlut_mode_e;

  typedef enum logic [1:0] {
    WK_NONE  = 2'd0,
    WK_POKE  = 2'd1,
    WK_SHIFT = 2'd2
  } wr_kind_e;

  // Map the mode and enable onto the kind of write the store performs.
  function automatic wr_kind_e decode_write(input mlut_mode_e m, input logic en);
    wr_kind_e k;
    k = WK_NONE;
    if (en) begin
      case (m)
        MODE_RAM:   k = WK_POKE;
        MODE_SHIFT: k = WK_SHIFT;
        default:    k = WK_NONE;
      endcase
    end
    return k;
  endfunction

endpackage

// File: rtl/mlut_store.sv
module mlut_store #(
  parameter int ADDR_W = 4
) (
  input  logic                      clk,
  input  mlut_pkg::mlut_mode_e      mode,
  input  logic [ADDR_W-1:0]         addr,
  input  logic                      we,
  input  logic                      din,
  input  logic                      ld,
  input  logic [(1<<ADDR_W)-1:0]    ld_word,
  output logic [(1<<ADDR_W)-1:0]    word_q,
  output logic                      ev_load,
  output logic                      ev_poke,
  output logic                      ev_shift
);
  import mlut_pkg::*;
  localparam int DEPTH = 1 << ADDR_W;

  wr_kind_e kind;

  always_comb kind = decode_write(mode, we);

  // Load wins over any mode-dependent write (R11).
  assign ev_load  = ld;
  assign ev_poke  = (kind == WK_POKE)  && !ld;
  assign ev_shift = (kind == WK_SHIFT) && !ld;

  for (genvar g = 0; g < DEPTH; g++) begin : g_bit
    localparam logic [ADDR_W-1:0] IDX = ADDR_W'(g);
    logic shift_src;
    if (g == 0) begin : g_head
      assign shift_src = din;
    end else begin : g_body
      assign shift_src = word_q[g-1];
    end
    always_ff @(posedge clk) begin
      if (ev_load)                      word_q[g] <= ld_word[g];
      else if (ev_poke && addr == IDX)  word_q[g] <= din;      // R3
      else if (ev_shift)                word_q[g] <= shift_src; // R6
    end
  end

endmodule

// File: rtl/mlut_tap_mux.sv
module mlut_tap_mux #(
  parameter int ADDR_W = 4
) (
  input  logic [(1<<ADDR_W)-1:0] word,
  input  logic [ADDR_W-1:0]      sel,
  output logic                   bit_o
);
  localparam int DEPTH = 1 << ADDR_W;

  function automatic logic pick(input logic [DEPTH-1:0] w, input logic [ADDR_W-1:0] a);
    logic r;
    r = 1'b0;
    for (int k = 0; k < DEPTH; k++) begin
      if (a == ADDR_W'(k)) r = w[k];
    end
    return r;
  endfunction

  always_comb bit_o = pick(word, sel);

endmodule

// File: rtl/mlut_out_stage.sv
module mlut_out_stage (
  input  logic clk,
  input  logic rst,
  input  logic d,
  input  logic bypass,
  output logic q_reg,
  output logic q
);

  always_ff @(posedge clk) begin
    if (rst) q_reg <= 1'b0;   // R9
    else     q_reg <= d;
  end

  assign q = bypass ? d : q_reg;

endmodule

// File: rtl/mlut_cell.sv
module mlut_cell #(
  parameter int ADDR_W = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [1:0]                 mode_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic                       we_i,
  input  logic                       din_i,
  input  logic                       init_load_i,
  input  logic [(1<<ADDR_W)-1:0]     init_data_i,
  input  logic                       obypass_i,
  output logic                       dout_o,
  output logic                       cascade_o
);
  import mlut_pkg::*;
  localparam int DEPTH = 1 << ADDR_W;

  mlut_mode_e       mode;
  logic [DEPTH-1:0] mem_q;
  logic             rd_bit;
  logic             oreg_q;
  logic             ev_load, ev_poke, ev_shift;

  assign mode = mlut_mode_e'(mode_i);

  mlut_store #(.ADDR_W(ADDR_W)) u_store (
    .clk(clk), .mode(mode), .addr(addr_i), .we(we_i), .din(din_i),
    .ld(init_load_i), .ld_word(init_data_i), .word_q(mem_q),
    .ev_load(ev_load), .ev_poke(ev_poke), .ev_shift(ev_shift)
  );

  mlut_tap_mux #(.ADDR_W(ADDR_W)) u_mux (
    .word(mem_q), .sel(addr_i), .bit_o(rd_bit)
  );

  mlut_out_stage u_out (
    .clk(clk), .rst(rst), .d(rd_bit), .bypass(obypass_i),
    .q_reg(oreg_q), .q(dout_o)
  );

  assign cascade_o = mem_q[DEPTH-1]; // R8

endmodule

// File: rtl/mlut_cell_chk.sv
module mlut_cell_chk #(
  parameter int ADDR_W = 4
) (
  input logic                   clk,
  input logic                   rst,
  input logic [1:0]             mode_i,
  input logic [ADDR_W-1:0]      addr_i,
  input logic                   din_i,
  input logic [(1<<ADDR_W)-1:0] init_data_i,
  input logic                   obypass_i,
  input logic                   dout_o,
  input logic                   cascade_o,
  input logic [(1<<ADDR_W)-1:0] mem_q,
  input logic                   rd_bit,
  input logic                   oreg_q,
  input logic                   ev_load,
  input logic                   ev_poke,
  input logic                   ev_shift
);
  localparam int DEPTH = 1 << ADDR_W;

  logic armed = 1'b0;
  logic rst_q = 1'b0;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b1;
    rst_q <= rst;
  end

  assert_logic_hold_R2: assert property (@(posedge clk) disable iff (rst || !armed)
    ((mode_i == 2'd0 || mode_i == 2'd3) && !ev_load) |=> $stable(mem_q));

  assert_ram_write_R3: assert property (@(posedge clk) disable iff (rst || !armed)
    ev_poke |=> (mem_q[$past(addr_i)] == $past(din_i)));

  assert_async_read_R4: assert property (@(posedge clk) disable iff (rst || !armed)
    obypass_i |-> (dout_o == rd_bit));

  assert_sync_read_R5: assert property (@(posedge clk) disable iff (rst || !armed)
    !obypass_i |-> (dout_o == oreg_q));

  assert_flop_capture_R5: assert property (@(posedge clk) disable iff (rst || !armed)
    1'b1 |=> (oreg_q == $past(rd_bit)));

  assert_shift_step_R6: assert property (@(posedge clk) disable iff (rst || !armed)
    ev_shift |=> (mem_q == {$past(mem_q[DEPTH-2:0]), $past(din_i)}));

  assert_cascade_R8: assert property (@(posedge clk) disable iff (rst || !armed)
    ev_shift |=> (cascade_o == $past(mem_q[DEPTH-2])));

  assert_flop_clear_R9: assert property (@(posedge clk)
    rst_q |-> (oreg_q == 1'b0));

  assert_load_R11: assert property (@(posedge clk) disable iff (rst || !armed)
    ev_load |=> (mem_q == $past(init_data_i)));

endmodule

bind mlut_cell mlut_cell_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .mode_i(mode_i), .addr_i(addr_i), .din_i(din_i),
  .init_data_i(init_data_i), .obypass_i(obypass_i), .dout_o(dout_o),
  .cascade_o(cascade_o), .mem_q(mem_q), .rd_bit(rd_bit), .oreg_q(oreg_q),
  .ev_load(ev_load), .ev_poke(ev_poke), .ev_shift(ev_shift)
);

// File: tb/tb_mlut_cell.sv
module tb_mlut_cell;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  mode = 2'd0;
  logic [3:0]  addr = 4'd0;
  logic        we = 1'b0, din = 1'b0, ld = 1'b0, byp = 1'b1;
  logic [15:0] ldata = 16'h0;
  logic        dout, casc;

  mlut_cell dut (
    .clk(clk), .rst(rst), .mode_i(mode), .addr_i(addr), .we_i(we), .din_i(din),
    .init_load_i(ld), .init_data_i(ldata), .obypass_i(byp),
    .dout_o(dout), .cascade_o(casc)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc = cyc + 1;

  typedef struct { int at; int req; logic exp; bit is_casc; } item_t;
  item_t sbq[$];

  logic [15:0] m = 16'h0;   // behavioural model of the stored word
  logic        oexp = 1'b0; // value the output flop will hold next cycle
  int total = 0, bad = 0;

  // Driver: apply one cycle of stimulus, queue the expected observations.
  task automatic drive(input logic r, input logic [1:0] md, input logic [3:0] a,
                       input logic w, input logic d, input logic l,
                       input logic [15:0] lv, input logic b, input int req);
    item_t it;
    @(posedge clk); #1;
    rst = r; mode = md; addr = a; we = w; din = d; ld = l; ldata = lv; byp = b;
    if (req != 0) begin
      it.at = cyc; it.req = req; it.is_casc = 1'b0;
      it.exp = b ? m[a] : oexp;
      sbq.push_back(it);
      if (req == 8) begin
        it.is_casc = 1'b1; it.exp = m[15];
        sbq.push_back(it);
      end
    end
    oexp = r ? 1'b0 : m[a];
    if (l) m = lv;
    else if (md == 2'd1 && w) m[a] = d;
    else if (md == 2'd2 && w) m = {m[14:0], d};
  endtask

  // Monitor: compare at the falling edge.
  always @(negedge clk) begin
    while (sbq.size() > 0 && sbq[0].at <= cyc) begin
      item_t it;
      logic act;
      it = sbq.pop_front();
      act = it.is_casc ? casc : dout;
      total++;
      if (it.at != cyc || act !== it.exp) begin
        bad++;
        $display("FAIL R%0d cyc=%0d %s actual=%b expected=%b", it.req, cyc,
                 it.is_casc ? "cascade" : "dout", act, it.exp);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    bad++; total++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  logic [15:0] pat, ram, seq;

  initial begin
    for (int i = 0; i < 16; i++) pat[i] = ^(i[3:0]) ^ i[0] ^ (i[3] & i[1]);
    ram = 16'h3C96;
    seq = 16'hB3A5;

    // Reset with a load; the flop reads 0 afterwards (R9)
    drive(1, 2'd0, 4'd0, 0, 0, 1, pat, 1, 0);
    drive(1, 2'd0, 4'd3, 0, 0, 0, 16'h0, 0, 9);  // R9
    drive(0, 2'd0, 4'd5, 0, 0, 0, 16'h0, 0, 9);  // R9

    // R1: truth table readout in logic mode
    for (int i = 0; i < 16; i++) drive(0, 2'd0, i[3:0], 0, 0, 0, 16'h0, 1, 1);
    // R4: jumping addresses, same-cycle response
    for (int i = 0; i < 16; i++) drive(0, 2'd0, 4'(i * 7), 0, 0, 0, 16'h0, 1, 4);
    // R2: writes with inverted data in logic mode are ignored
    for (int i = 0; i < 16; i++) drive(0, 2'd0, i[3:0], 1, ~pat[i], 0, 16'h0, 1, 2);
    for (int i = 0; i < 16; i++) drive(0, 2'd0, i[3:0], 0, 0, 0, 16'h0, 1, 2);
    // R12: reserved mode ignores writes and shifts
    for (int i = 0; i < 16; i++) drive(0, 2'd3, i[3:0], 1, ~pat[i], 0, 16'h0, 1, 12);
    for (int i = 0; i < 16; i++) drive(0, 2'd3, i[3:0], 0, 0, 0, 16'h0, 1, 12);

    // R3: RAM writes, then readback
    for (int i = 0; i < 16; i++) drive(0, 2'd1, i[3:0], 1, ram[i], 0, 16'h0, 1, 3);
    for (int i = 0; i < 16; i++) drive(0, 2'd1, 4'(15 - i), 0, 0, 0, 16'h0, 1, 3);
    // R5: registered read in RAM mode
    for (int i = 0; i < 17; i++) drive(0, 2'd1, 4'(i * 5), 0, 0, 0, 16'h0, 0, 5);
    // R10: switch to logic mode, contents retained
    for (int i = 0; i < 16; i++) drive(0, 2'd0, i[3:0], 0, 0, 0, 16'h0, 1, 10);

    // R6/R8: clear, then shift with taps and cascade observed
    drive(0, 2'd2, 4'd0, 0, 0, 1, 16'h0, 1, 0);
    for (int i = 0; i < 40; i++) drive(0, 2'd2, 4'(i * 3), 1, seq[i % 16] ^ i[4], 0, 16'h0, 1, 6);
    for (int i = 0; i < 20; i++) drive(0, 2'd2, 4'(i), 1, seq[(i + 5) % 16], 0, 16'h0, 1, 8);
    // R7: shift enable low holds the word
    for (int i = 0; i < 16; i++) drive(0, 2'd2, i[3:0], 0, ~seq[i], 0, 16'h0, 1, 7);
    // R5: registered tap in shift mode (extra stage)
    for (int i = 0; i < 18; i++) drive(0, 2'd2, 4'(i % 4), 1, seq[i % 16], 0, 16'h0, 0, 5);

    // R11: load beats a RAM write and a shift in the same cycle
    drive(0, 2'd1, 4'd2, 1, 1, 1, 16'h0F0B, 1, 11);
    for (int i = 0; i < 16; i++) drive(0, 2'd1, i[3:0], 0, 0, 0, 16'h0, 1, 11);
    drive(0, 2'd2, 4'd0, 1, 1, 1, 16'h5A00, 1, 11);
    for (int i = 0; i < 16; i++) drive(0, 2'd2, i[3:0], 0, 0, 0, 16'h0, 1, 11);

    // R9: mid-run reset clears the flop only, word survives
    drive(0, 2'd2, 4'd9, 0, 0, 0, 16'h0, 0, 5);
    drive(1, 2'd2, 4'd9, 0, 0, 0, 16'h0, 0, 5);
    drive(0, 2'd2, 4'd9, 0, 0, 0, 16'h0, 0, 9);
    for (int i = 0; i < 16; i++) drive(0, 2'd0, i[3:0], 0, 0, 0, 16'h0, 1, 9);

    drive(0, 2'd0, 4'd0, 0, 0, 0, 16'h0, 1, 0);
    repeat (3) @(posedge clk);
    if (sbq.size() != 0) begin
      bad++; total++;
      $display("FAIL scoreboard actual=%0d pending expected=0", sbq.size());
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule